// File: doc/BRIEF.md
# Plane Gradient Intra Predictor (16x16)

This block builds a 16x16 block of 8-bit prediction samples as a clipped linear surface. The surface is fitted from the 16 reconstructed samples directly above the block, the 16 samples directly to its left, and the single sample at the above-left corner. The neighbour samples and a one-cycle start strobe are presented together. One cycle later the block has registered its horizontal gradient sum, its vertical gradient sum and its base term. From the next cycle on, it emits one complete 16-sample row per clock for 16 consecutive clocks.

Inside the block, each of the 16 columns keeps its own signed running value. Row zero is seeded by stepping the horizontal slope across the columns, and each later row adds the vertical slope to every column. No general multiplier is needed. Every sample is saturated before it is scaled down, so negative or oversized running values clip cleanly instead of wrapping.

The block does not check which neighbours are available, does not select a prediction mode and does not access memory. It expects the caller to supply valid neighbour samples.

Top module: `plane_pred`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with start low, `row_valid` and `done` are 0. A reset during a run ends the run at once.
- R2: A start seen at a clock edge while the block is idle begins a run. In the cycle after that edge `row_valid` is 0. Row 0 then appears in the next cycle, and rows 1 to 15 follow on the 15 cycles after it, in order.
- R3: The horizontal gradient H is the sum over k = 1..8 of k*(above[7+k] - above[7-k]), where above[-1] is the corner sample. `top_row` bits [8j+7:8j] carry above[j].
- R4: The vertical gradient V is the sum over k = 1..8 of k*(left[7+k] - left[7-k]), where left[-1] is the corner sample. `side_col` bits [8j+7:8j] carry left[j].
- R5: The column slope is b = (5*H + 32) >> 6 and the row slope is c = (5*V + 32) >> 6. Both shifts round toward minus infinity. The start value is d = 16*(above[15] + left[15]) + 16 - 7*b - 7*c.
- R6: The sample at column x of row y is min(max(d + x*b + y*c, 0), 8191) >> 5. It is carried on `row_data` bits [8x+7:8x].
- R7: A running value below 0 yields sample 0, and one above 8191 yields sample 255. Neither wraps around.
- R8: `done` is 1 for exactly one cycle per run, the cycle that carries row 15, and `row_valid` is 0 in the cycle after it.
- R9: While a run is in progress, including the cycle of row 15, start and changes on the neighbour inputs are ignored. The remaining rows are unchanged, and no new run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; taken only while idle |
| top_row | input | 128 | Above neighbours, sample j in bits [8j+7:8j] |
| side_col | input | 128 | Left neighbours, sample j in bits [8j+7:8j] |
| corner | input | 8 | Above-left corner sample |
| row_valid | output | 1 | A prediction row is present on row_data |
| row_data | output | 128 | Current row, column x in bits [8x+7:8x] |
| done | output | 1 | Marks the final row of a run |

## Verification
The case that needs care is a new start request arriving in the same cycle as the final row, while `done` is high. The bench raises start exactly in the row-15 cycle, and also in the middle of a run. At the same time it inverts every neighbour input. It then judges the outcome at the ports: the rows must still match the model built from the original neighbours, and `row_valid` must stay low on the two cycles after `done`. Saturation at both ends is provoked with steep rising and falling ramps. Hand-derived corner samples of 255 and 0 are checked for those ramps, and every sample is compared with a direct-formula model.

// File: rtl/plane_pred_pkg.sv
package plane_pred_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_GRAD = 2'd1,
      PH_ROWS = 2'd2
   } phase_t;

   // Width that holds 5*H + 32 for the given sample width and block size.
   function automatic int grad_width(input int sw, input int n);
      return sw + $clog2(n) + 6;
   endfunction

endpackage

// File: rtl/plane_grad.sv
module plane_grad #(
   parameter int N  = 16,
   parameter int SW = 8,
   parameter int GW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [N*SW-1:0]      top_row,
   input  logic [N*SW-1:0]      side_col,
   input  logic [SW-1:0]        corner,
   output logic signed [GW-1:0] h_grad,
   output logic signed [GW-1:0] v_grad,
   output logic signed [GW-1:0] base_a
);
   localparam int HALF = N / 2;

   logic signed [GW-1:0] h_sum, v_sum, a_sum;

   // Weighted symmetric differences, folded to one weight per sample:
   // sample j gets weight (j - HALF + 1), the corner gets -HALF.
   always_comb begin
      h_sum = GW'(-HALF) * GW'(signed'({1'b0, corner}));
      v_sum = GW'(-HALF) * GW'(signed'({1'b0, corner}));
      for (int j = 1; j <= N; j++) begin
         h_sum = h_sum + GW'(j - HALF) * GW'(signed'({1'b0, top_row[(j-1)*SW +: SW]}));
         v_sum = v_sum + GW'(j - HALF) * GW'(signed'({1'b0, side_col[(j-1)*SW +: SW]}));
      end
      a_sum = (GW'(signed'({1'b0, top_row[(N-1)*SW +: SW]})) +
               GW'(signed'({1'b0, side_col[(N-1)*SW +: SW]}))) * GW'(16);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_grad <= '0;
         v_grad <= '0;
         base_a <= '0;
      end else if (capture) begin
         h_grad <= h_sum;
         v_grad <= v_sum;
         base_a <= a_sum;
      end
   end

endmodule

// File: rtl/plane_lane.sv
module plane_lane #(
   parameter int SW    = 8,
   parameter int ACC_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    step,
   input  logic signed [ACC_W-1:0] init,
   input  logic signed [ACC_W-1:0] incr,
   output logic [SW-1:0]           sample
);
   localparam logic signed [ACC_W-1:0] LIMIT = ACC_W'((1 << (SW + 5)) - 1);

   logic signed [ACC_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= '0;
      else if (load)
         run <= init;
      else if (step)
         run <= run + incr;
   end

   always_comb begin
      if (run < 0)
         sample = '0;
      else if (run > LIMIT)
         sample = '1;
      else
         sample = run[SW+4:5];
   end

endmodule

// File: rtl/plane_ctrl.sv
module plane_ctrl
   import plane_pred_pkg::*;
#(
   parameter int N = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic capture,
   output logic load,
   output logic step,
   output logic row_valid,
   output logic done
);
   localparam int             CW   = $clog2(N);
   localparam logic [CW-1:0]  LAST = CW'(N - 1);

   phase_t        phase;
   logic [CW-1:0] row_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         row_cnt <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) phase <= PH_GRAD;
            PH_GRAD: begin
               phase   <= PH_ROWS;
               row_cnt <= '0;
            end
            PH_ROWS: begin
               row_cnt <= row_cnt + 1'b1;
               if (row_cnt == LAST) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign capture   = (phase == PH_IDLE) && start;
   assign load      = (phase == PH_GRAD);
   assign step      = (phase == PH_ROWS);
   assign row_valid = (phase == PH_ROWS);
   assign done      = (phase == PH_ROWS) && (row_cnt == LAST);

   // R2: one quiet cycle between an accepted start and row 0
   assert_gap_then_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !row_valid ##1 row_valid);

   // R8: done only travels with a row, and the run ends right after it
   assert_done_with_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> row_valid);
   assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !row_valid);

   // R9: a start during a run neither cuts it short nor chains a new one
   assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && !done && start) |=> row_valid);
   assert_last_row_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !row_valid ##1 !row_valid);

endmodule

// File: rtl/plane_pred.sv
module plane_pred
   import plane_pred_pkg::*;
#(
   parameter int N     = 16,
   parameter int SW    = 8,
   parameter int ACC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N*SW-1:0] top_row,
   input  logic [N*SW-1:0] side_col,
   input  logic [SW-1:0]   corner,
   output logic            row_valid,
   output logic [N*SW-1:0] row_data,
   output logic            done
);
   localparam int GW = grad_width(SW, N);

   generate
      if (N != 16) begin : g_bad_size
         $error("plane_pred: slope scaling is defined for a 16x16 block only");
      end
      if (ACC_W < SW + 8) begin : g_bad_acc
         $error("plane_pred: ACC_W must be at least SW+8 so running values do not wrap");
      end
   endgenerate

   logic capture, load, step;
   logic signed [GW-1:0] h_grad, v_grad, base_a;
   logic signed [GW-1:0] b_g, c_g, d_g;
   logic signed [ACC_W-1:0] b_acc, c_acc, d_acc;

   plane_ctrl #(.N(N)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .capture   (capture),
      .load      (load),
      .step      (step),
      .row_valid (row_valid),
      .done      (done)
   );

   plane_grad #(.N(N), .SW(SW), .GW(GW)) u_grad (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .top_row  (top_row),
      .side_col (side_col),
      .corner   (corner),
      .h_grad   (h_grad),
      .v_grad   (v_grad),
      .base_a   (base_a)
   );

   // Slopes with sign-preserving rounding shift, then the start value.
   assign b_g = (h_grad * GW'(5) + GW'(32)) >>> 6;
   assign c_g = (v_grad * GW'(5) + GW'(32)) >>> 6;
   assign d_g = base_a + GW'(16) - GW'(7) * b_g - GW'(7) * c_g;

   assign b_acc = ACC_W'(b_g);
   assign c_acc = ACC_W'(c_g);
   assign d_acc = ACC_W'(d_g);

   // Column seeds form an adder chain: seed[x] = seed[x-1] + b.
   for (genvar x = 0; x < N; x++) begin : g_col
      logic signed [ACC_W-1:0] seed;
      if (x == 0) begin : g_first
         assign seed = d_acc;
      end else begin : g_next
         assign seed = g_col[x-1].seed + b_acc;
      end

      plane_lane #(.SW(SW), .ACC_W(ACC_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load),
         .step   (step),
         .init   (seed),
         .incr   (c_acc),
         .sample (row_data[x*SW +: SW])
      );
   end

   // R6: with a non-negative row slope, column 0 never decreases row to row
   assert_col0_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && $past(row_valid) && !c_g[GW-1]) |->
         (row_data[SW-1:0] >= $past(row_data[SW-1:0])));

   // R8: done never appears outside a valid row at the top level
   assert_done_valid_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> row_valid);

endmodule

// File: tb/sim_plane_pred.sv
module sim_plane_pred;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {kind[1:0], above base, above step, left base, left step, corner}
   localparam logic [41:0] VEC [0:NVEC-1] = '{
      {2'd0, 8'd100, 8'd0,   8'd100, 8'd0,   8'd100},
      {2'd0, 8'd10,  8'd10,  8'd20,  8'd5,   8'd5  },
      {2'd0, 8'd0,   8'd17,  8'd0,   8'd17,  8'd0  },
      {2'd0, 8'd255, 8'd239, 8'd255, 8'd239, 8'd255},
      {2'd1, 8'h5A,  8'd37,  8'hC3,  8'd91,  8'h40 },
      {2'd0, 8'd200, 8'd246, 8'd30,  8'd12,  8'd128}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] top_row = '0;
   logic [127:0] side_col = '0;
   logic [7:0]   corner = '0;
   logic         row_valid;
   logic [127:0] row_data;
   logic         done;

   int errors = 0;
   int checks = 0;
   int ab [16];
   int lb [16];
   int cr;

   plane_pred u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .top_row(top_row),
      .side_col(side_col), .corner(corner), .row_valid(row_valid),
      .row_data(row_data), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference straight from the formulas (direct multiply, no stepping).
   function automatic logic [127:0] exp_row(input int y);
      int h, v, b, c, d, val;
      logic [127:0] r;
      h = -8 * cr;
      v = -8 * cr;
      for (int j = 0; j < 16; j++) begin
         h += (j - 7) * ab[j];
         v += (j - 7) * lb[j];
      end
      b = (5 * h + 32) >>> 6;
      c = (5 * v + 32) >>> 6;
      d = 16 * (ab[15] + lb[15]) + 16 - 7 * b - 7 * c;
      for (int x = 0; x < 16; x++) begin
         val = d + x * b + y * c;
         if (val < 0) val = 0;
         if (val > 8191) val = 8191;
         r[x*8 +: 8] = 8'(val >>> 5);
      end
      return r;
   endfunction

   task automatic load_vec(input int i);
      logic [41:0] v;
      v = VEC[i];
      for (int k = 0; k < 16; k++) begin
         if (v[41:40] == 2'd0) begin
            ab[k] = (int'(v[39:32]) + k * int'(v[31:24])) & 255;
            lb[k] = (int'(v[23:16]) + k * int'(v[15:8])) & 255;
         end else begin
            ab[k] = ((k * int'(v[31:24]) + int'(v[39:32])) ^ (k << 4)) & 255;
            lb[k] = ((k * int'(v[15:8]) + int'(v[23:16])) ^ (k << 3)) & 255;
         end
         top_row[k*8 +: 8]  = 8'(ab[k]);
         side_col[k*8 +: 8] = 8'(lb[k]);
      end
      cr = int'(v[7:0]);
      corner = v[7:0];
   endtask

   // Called at a negedge with inputs loaded; returns at a negedge, idle.
   task automatic run_vec(input bit disturb);
      logic [127:0] e;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         top_row = ~top_row; side_col = ~side_col; corner = ~corner;
      end
      chk(row_valid == 1'b0, "R2 quiet cycle after start", {127'd0, row_valid}, 128'd0);
      for (int r = 0; r < 16; r++) begin
         @(posedge clk); @(negedge clk);
         e = exp_row(r);
         chk(row_valid == 1'b1, "R2 row_valid during rows", {127'd0, row_valid}, 128'd1);
         chk(row_data == e, disturb ? "R9 row after ignored start" : "R3 R4 R5 R6 row data",
             row_data, e);
         chk(done == (r == 15), "R8 done on last row only", {127'd0, done}, {127'd0, r == 15});
         start = disturb && (r == 5 || r == 15);
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk(!row_valid && !done, "R8 idle after last row", {126'd0, row_valid, done}, 128'd0);
      if (disturb) begin
         @(posedge clk); @(negedge clk);
         chk(!row_valid, "R9 no run from last-row start", {127'd0, row_valid}, 128'd0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      chk(!row_valid && !done, "R1 outputs in reset", {126'd0, row_valid, done}, 128'd0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(!row_valid && !done, "R1 outputs after reset", {126'd0, row_valid, done}, 128'd0);

      // Table walk: each vector runs a full block against the model.
      for (int i = 0; i < NVEC; i++) begin
         load_vec(i);
         run_vec(1'b0);
      end

      // Hand-derived values: flat block, and both saturation ends (R7).
      load_vec(0);
      start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(row_data == {16{8'd100}}, "R6 flat neighbours give flat block", row_data, {16{8'd100}});
      repeat (16) @(negedge clk);

      load_vec(2);
      start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(row_data[7:0] == 8'd23, "R5 steep ramp top-left", {120'd0, row_data[7:0]}, 128'd23);
      repeat (15) begin @(posedge clk); @(negedge clk); end
      chk(row_data[127:120] == 8'd255, "R7 high saturation", {120'd0, row_data[127:120]}, 128'd255);
      @(posedge clk); @(negedge clk);

      load_vec(3);
      start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      repeat (16) begin @(posedge clk); @(negedge clk); end
      chk(row_data[127:120] == 8'd0, "R7 low saturation", {120'd0, row_data[127:120]}, 128'd0);
      chk(row_data[7:0] == exp_row(15) >> 0 & 128'hFF, "R5 negative slope floor shift",
          {120'd0, row_data[7:0]}, exp_row(15) & 128'hFF);
      @(posedge clk); @(negedge clk);

      // R9: start and new inputs during a run, including the last-row cycle
      load_vec(4);
      run_vec(1'b1);
      load_vec(1);
      run_vec(1'b1);

      // R1: reset in the middle of a run
      load_vec(5);
      start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      rst_n = 1'b0;
      #1;
      chk(!row_valid && !done, "R1 reset aborts run", {126'd0, row_valid, done}, 128'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(!row_valid, "R1 stays idle after abort", {127'd0, row_valid}, 128'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule